// File: doc/BRIEF.md
# Auxiliary System Control Register Block

This block gathers the small control registers that a workstation I/O companion device exposes to software: four byte-wide registers (configuration, diagnostic, modem control, miscellaneous functions), a byte-wide power-down control register, a 16-bit diagnostic LED register and a 32-bit system-control register. A one-byte idle-controller location sits in the same bank. Software reaches each register through a simple bus. The bus carries a register select code, an access-size code, a write strobe, write data and combinational read data.

The block turns register writes into single-cycle request pulses for its neighbours. These are a floppy terminal-count strobe, a shutdown request, a system-reset request and a CPU-halt request. It also keeps a sticky power-fail status bit, which it sets from an external power-fail input. That status bit drives a registered interrupt, gated by an enable bit in the configuration register. Software may clear the status bit but may never set it.

Top module: `aux_sysctl_regs`

## Requirements
- R1: `pwr_irq` is high exactly when the power-fail status (power-down register bit 5) and the power-interrupt enable (configuration bit 3) are both set. It follows a write or an input change on the clock edge that applies that change.
- R2: When `pwr_fail_in` changes level, the status bit becomes 1 only if the new level is 1 and configuration bit 3 is already set. Any other change clears the status bit.
- R3: A write to the power-down register keeps only data bits 0 and 1 and never sets bit 5. Writing bit 1 as 1 clears the status bit. Otherwise the status bit keeps its value.
- R4: A write to the power-down register with data bit 0 set gives a `shutdown_req` pulse exactly one clock long.
- R5: A word write to system control with data bit 0 set loads the value 0x00000002 and gives a one-clock `sys_reset_req` pulse. Any other word write stores the data unchanged.
- R6: Reset clears configuration, modem control, miscellaneous and power-down registers, and `pwr_irq`. The diagnostic, LED and system-control registers keep their contents through reset.
- R7: The byte registers, the power-down register and the idle location accept only size code 0 (byte). LED accepts only code 1 (half). System control accepts only code 2 (word). A write of any other size changes nothing, and a read of any other size returns zero.
- R8: A byte write to the miscellaneous register with data bit 0 set gives a one-clock `fd_tc_pulse`. The register stores the whole written byte.
- R9: A byte write to the idle location (select 7) gives a one-clock `cpu_halt_req` pulse. Reads of that location return zero.
- R10: A read returns the stored value zero-extended to 32 bits. While `acc_en` is low, `acc_rdata` is zero. Select codes are: 0 configuration, 1 diagnostic, 2 modem, 3 miscellaneous, 4 power-down, 5 LED, 6 system control, 7 idle.
- R11: When a power-down write with bit 1 set and a `pwr_fail_in` change land on the same edge, the clear wins and the status bit ends at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Bus access valid |
| acc_we | input | 1 | Access is a write |
| acc_sel | input | 3 | Register select code |
| acc_size | input | 2 | Access size: 0 byte, 1 half, 2 word |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, zero when idle or size mismatched |
| pwr_fail_in | input | 1 | Power-fail indication from the supply monitor |
| pwr_irq | output | 1 | Power-fail interrupt |
| fd_tc_pulse | output | 1 | One-clock floppy terminal-count strobe |
| shutdown_req | output | 1 | One-clock shutdown request |
| sys_reset_req | output | 1 | One-clock system-reset request |
| cpu_halt_req | output | 1 | One-clock CPU-halt request |

## Verification
The bench builds the block with its default parameters. These are a 32-bit bus built from 8-bit lanes, a 16-bit LED register and the registered interrupt variant. With these values the bench can reach every width-mismatch path for every register class. The interrupt is checked one edge after each enable or status change. Because the bench can pulse reset in the middle of a run, the registers that must survive reset can be told apart from those that must be cleared.

// File: rtl/auxsc_pkg.sv
package auxsc_pkg;
   typedef enum logic [2:0] {
      SEL_CFG  = 3'd0,
      SEL_DIAG = 3'd1,
      SEL_MDM  = 3'd2,
      SEL_AUX1 = 3'd3,
      SEL_AUX2 = 3'd4,
      SEL_LED  = 3'd5,
      SEL_SYS  = 3'd6,
      SEL_IDLE = 3'd7
   } sel_e;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2
   } size_e;

   localparam int NUM_SEL       = 8;
   localparam int CFG_PIE_BIT   = 3;
   localparam int AUX2_OFF_BIT  = 0;
   localparam int AUX2_CLR_BIT  = 1;
   localparam int AUX2_STAT_BIT = 5;
   localparam int AUX1_TC_BIT   = 0;
   localparam int SYS_RST_BIT   = 0;
   localparam int SYS_STAT_BIT  = 1;
endpackage

// File: rtl/auxsc_decode.sv
module auxsc_decode
   import auxsc_pkg::*;
#(
   parameter int NSEL = NUM_SEL
) (
   input  logic            acc_en,
   input  logic            acc_we,
   input  logic [2:0]      acc_sel,
   input  logic [1:0]      acc_size,
   output logic            size_ok,
   output logic [NSEL-1:0] wr_hit
);
   always_comb begin
      unique case (acc_sel)
         SEL_LED: size_ok = (acc_size == SZ_HALF);
         SEL_SYS: size_ok = (acc_size == SZ_WORD);
         default: size_ok = (acc_size == SZ_BYTE);
      endcase
   end

   always_comb begin
      wr_hit = '0;
      if (acc_en && acc_we && size_ok) wr_hit[acc_sel] = 1'b1;
   end
endmodule

// File: rtl/auxsc_byte_bank.sv
module auxsc_byte_bank #(
   parameter int             NREG     = 4,
   parameter int             W        = 8,
   parameter logic [NREG-1:0] RST_MASK = '1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NREG-1:0]         we,
   input  logic [W-1:0]            wdata,
   output logic [NREG-1:0][W-1:0]  q
);
   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (RST_MASK[i]) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n)     q[i] <= '0;
            else if (we[i]) q[i] <= wdata;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (we[i]) q[i] <= wdata;
         end
      end
   end
endmodule

// File: rtl/auxsc_pwr_unit.sv
module auxsc_pwr_unit
   import auxsc_pkg::*;
#(
   parameter int W       = 8,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         pf_in,
   input  logic         pie_we,
   input  logic         pie_wbit,
   input  logic         pie_q,
   input  logic         aux2_we,
   input  logic [1:0]   aux2_wbits,
   output logic [W-1:0] aux2_q,
   output logic         pf_stat,
   output logic         irq,
   output logic         shutdown
);
   logic       pf_q;
   logic [1:0] low_q;
   logic       stat_q, stat_d, pie_d;
   logic       pf_chg;

   assign pf_chg = pf_in ^ pf_q;
   assign pie_d  = pie_we ? pie_wbit : pie_q;

   always_comb begin
      stat_d = stat_q;
      if (aux2_we && aux2_wbits[AUX2_CLR_BIT]) stat_d = 1'b0;
      else if (pf_chg)                          stat_d = pf_in & pie_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pf_q     <= 1'b0;
         low_q    <= '0;
         stat_q   <= 1'b0;
         shutdown <= 1'b0;
      end else begin
         pf_q     <= pf_in;
         stat_q   <= stat_d;
         shutdown <= aux2_we & aux2_wbits[AUX2_OFF_BIT];
         if (aux2_we) low_q <= aux2_wbits;
      end
   end

   if (IRQ_REG) begin : g_irq_reg
      always_ff @(posedge clk) begin
         if (!rst_n) irq <= 1'b0;
         else        irq <= stat_d & pie_d;
      end
   end else begin : g_irq_comb
      assign irq = stat_q & pie_q;
   end

   always_comb begin
      aux2_q                = '0;
      aux2_q[1:0]           = low_q;
      aux2_q[AUX2_STAT_BIT] = stat_q;
   end
   assign pf_stat = stat_q;
endmodule

// File: rtl/aux_sysctl_regs.sv
module aux_sysctl_regs
   import auxsc_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int BYTE_W  = 8,
   parameter int HALF_W  = 16,
   parameter bit IRQ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_we,
   input  logic [2:0]        acc_sel,
   input  logic [1:0]        acc_size,
   input  logic [DATA_W-1:0] acc_wdata,
   output logic [DATA_W-1:0] acc_rdata,
   input  logic              pwr_fail_in,
   output logic              pwr_irq,
   output logic              fd_tc_pulse,
   output logic              shutdown_req,
   output logic              sys_reset_req,
   output logic              cpu_halt_req
);
   localparam int             NBANK     = 4;
   localparam logic [NBANK-1:0] BANK_RST = 4'b1101;

   if (DATA_W != 4 * BYTE_W) begin : g_chk_dw
      $error("DATA_W must be four byte lanes");
   end
   if (HALF_W != 2 * BYTE_W) begin : g_chk_hw
      $error("HALF_W must be two byte lanes");
   end
   if (BYTE_W <= AUX2_STAT_BIT) begin : g_chk_bw
      $error("BYTE_W too narrow for status bit");
   end

   logic                         size_ok;
   logic [NUM_SEL-1:0]           wr_hit;
   logic [NBANK-1:0][BYTE_W-1:0] bank_q;
   logic [BYTE_W-1:0]            aux2_q;
   logic [HALF_W-1:0]            led_q;
   logic [DATA_W-1:0]            sys_q;
   logic                         pf_stat;
   logic                         pie;

   auxsc_decode #(.NSEL(NUM_SEL)) u_dec (
      .acc_en   (acc_en),
      .acc_we   (acc_we),
      .acc_sel  (acc_sel),
      .acc_size (acc_size),
      .size_ok  (size_ok),
      .wr_hit   (wr_hit)
   );

   auxsc_byte_bank #(.NREG(NBANK), .W(BYTE_W), .RST_MASK(BANK_RST)) u_bank (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_hit[NBANK-1:0]),
      .wdata (acc_wdata[BYTE_W-1:0]),
      .q     (bank_q)
   );

   assign pie = bank_q[SEL_CFG][CFG_PIE_BIT];

   auxsc_pwr_unit #(.W(BYTE_W), .IRQ_REG(IRQ_REG)) u_pwr (
      .clk        (clk),
      .rst_n      (rst_n),
      .pf_in      (pwr_fail_in),
      .pie_we     (wr_hit[SEL_CFG]),
      .pie_wbit   (acc_wdata[CFG_PIE_BIT]),
      .pie_q      (pie),
      .aux2_we    (wr_hit[SEL_AUX2]),
      .aux2_wbits (acc_wdata[1:0]),
      .aux2_q     (aux2_q),
      .pf_stat    (pf_stat),
      .irq        (pwr_irq),
      .shutdown   (shutdown_req)
   );

   // LED and system control keep their contents across block reset
   always_ff @(posedge clk) begin
      if (wr_hit[SEL_LED]) led_q <= acc_wdata[HALF_W-1:0];
      if (wr_hit[SEL_SYS]) begin
         if (acc_wdata[SYS_RST_BIT]) sys_q <= DATA_W'(1) << SYS_STAT_BIT;
         else                        sys_q <= acc_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fd_tc_pulse   <= 1'b0;
         sys_reset_req <= 1'b0;
         cpu_halt_req  <= 1'b0;
      end else begin
         fd_tc_pulse   <= wr_hit[SEL_AUX1] & acc_wdata[AUX1_TC_BIT];
         sys_reset_req <= wr_hit[SEL_SYS] & acc_wdata[SYS_RST_BIT];
         cpu_halt_req  <= wr_hit[SEL_IDLE];
      end
   end

   always_comb begin
      acc_rdata = '0;
      if (acc_en && size_ok) begin
         unique case (acc_sel)
            SEL_CFG, SEL_DIAG, SEL_MDM, SEL_AUX1:
               acc_rdata = DATA_W'(bank_q[acc_sel[1:0]]);
            SEL_AUX2: acc_rdata = DATA_W'(aux2_q);
            SEL_LED:  acc_rdata = DATA_W'(led_q);
            SEL_SYS:  acc_rdata = sys_q;
            default:  acc_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/aux_sysctl_regs_chk.sv
module aux_sysctl_regs_chk
   import auxsc_pkg::*;
#(
   parameter int DW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          acc_en,
   input logic          acc_we,
   input logic [2:0]    acc_sel,
   input logic [1:0]    acc_size,
   input logic [DW-1:0] acc_wdata,
   input logic [DW-1:0] acc_rdata,
   input logic          pwr_irq,
   input logic          fd_tc_pulse,
   input logic          shutdown_req,
   input logic          sys_reset_req,
   input logic          cpu_halt_req,
   input logic          pf_stat,
   input logic          pie
);
   p_irq_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_irq == (pf_stat && pie));

   p_stat_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pf_stat) |-> $past(pie));

   p_shutdown_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_req |-> $past(acc_en && acc_we && acc_sel == SEL_AUX2
                             && acc_size == SZ_BYTE && acc_wdata[AUX2_OFF_BIT]));

   p_reset_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sys_reset_req |-> $past(acc_en && acc_we && acc_sel == SEL_SYS
                              && acc_size == SZ_WORD && acc_wdata[SYS_RST_BIT]));

   p_tc_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fd_tc_pulse |-> $past(acc_en && acc_we && acc_sel == SEL_AUX1
                            && acc_size == SZ_BYTE && acc_wdata[AUX1_TC_BIT]));

   p_halt_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_halt_req |-> $past(acc_en && acc_we && acc_sel == SEL_IDLE
                             && acc_size == SZ_BYTE));

   p_idle_rdata_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_en |-> acc_rdata == '0);
endmodule

bind aux_sysctl_regs aux_sysctl_regs_chk #(.DW(DATA_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .acc_en        (acc_en),
   .acc_we        (acc_we),
   .acc_sel       (acc_sel),
   .acc_size      (acc_size),
   .acc_wdata     (acc_wdata),
   .acc_rdata     (acc_rdata),
   .pwr_irq       (pwr_irq),
   .fd_tc_pulse   (fd_tc_pulse),
   .shutdown_req  (shutdown_req),
   .sys_reset_req (sys_reset_req),
   .cpu_halt_req  (cpu_halt_req),
   .pf_stat       (pf_stat),
   .pie           (pie)
);

// File: tb/aux_sysctl_regs_bench.sv
`timescale 1ns/100ps
module aux_sysctl_regs_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_we = 1'b0;
   logic [2:0]  acc_sel = 3'd0;
   logic [1:0]  acc_size = 2'd0;
   logic [31:0] acc_wdata = 32'd0;
   logic [31:0] acc_rdata;
   logic        pwr_fail_in = 1'b0;
   logic        pwr_irq, fd_tc_pulse, shutdown_req, sys_reset_req, cpu_halt_req;

   int n_total = 0;
   int n_fail  = 0;

   always #2.5 clk = ~clk;

   aux_sysctl_regs u_aux_sysctl_regs (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_we(acc_we),
      .acc_sel(acc_sel), .acc_size(acc_size), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .pwr_fail_in(pwr_fail_in), .pwr_irq(pwr_irq),
      .fd_tc_pulse(fd_tc_pulse), .shutdown_req(shutdown_req),
      .sys_reset_req(sys_reset_req), .cpu_halt_req(cpu_halt_req)
   );

   typedef struct packed {
      logic [2:0]  sel;
      logic [1:0]  sz;
      logic        we;
      logic [31:0] d;
      logic [31:0] exp;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 20;
   localparam vec_t VT [NV] = '{
      '{3'd0, 2'd0, 1'b1, 32'h0000005A, 32'h0,        4'd10}, // R10 cfg write
      '{3'd0, 2'd0, 1'b0, 32'h0,        32'h0000005A, 4'd10}, // R10 cfg read
      '{3'd0, 2'd1, 1'b1, 32'h00000077, 32'h0,        4'd7},  // R7 wrong size write
      '{3'd0, 2'd0, 1'b0, 32'h0,        32'h0000005A, 4'd7},  // R7 unchanged
      '{3'd0, 2'd1, 1'b0, 32'h0,        32'h0,        4'd7},  // R7 wrong size read
      '{3'd1, 2'd0, 1'b1, 32'h000000A5, 32'h0,        4'd10}, // R10 diag
      '{3'd1, 2'd0, 1'b0, 32'h0,        32'h000000A5, 4'd10},
      '{3'd2, 2'd0, 1'b1, 32'hFFFFFF3C, 32'h0,        4'd10}, // R10 modem
      '{3'd2, 2'd0, 1'b0, 32'h0,        32'h0000003C, 4'd10},
      '{3'd5, 2'd1, 1'b1, 32'h1234BEEF, 32'h0,        4'd10}, // R10 LED
      '{3'd5, 2'd1, 1'b0, 32'h0,        32'h0000BEEF, 4'd10},
      '{3'd5, 2'd0, 1'b0, 32'h0,        32'h0,        4'd7},  // R7 LED byte read
      '{3'd5, 2'd2, 1'b1, 32'h00001234, 32'h0,        4'd7},  // R7 LED word write
      '{3'd5, 2'd1, 1'b0, 32'h0,        32'h0000BEEF, 4'd7},
      '{3'd6, 2'd2, 1'b1, 32'h12345670, 32'h0,        4'd5},  // R5 plain store
      '{3'd6, 2'd2, 1'b0, 32'h0,        32'h12345670, 4'd5},
      '{3'd6, 2'd1, 1'b0, 32'h0,        32'h0,        4'd7},  // R7 sys half read
      '{3'd7, 2'd0, 1'b0, 32'h0,        32'h0,        4'd9},  // R9 idle read
      '{3'd3, 2'd0, 1'b1, 32'h000000F0, 32'h0,        4'd8},  // R8 store byte
      '{3'd3, 2'd0, 1'b0, 32'h0,        32'h000000F0, 4'd8}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] s, input logic [1:0] z, input logic [31:0] d);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b1; acc_sel = s; acc_size = z; acc_wdata = d;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0; acc_wdata = 32'd0;
   endtask

   task automatic rd(input logic [2:0] s, input logic [1:0] z, output logic [31:0] v);
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b0; acc_sel = s; acc_size = z;
      #1 v = acc_rdata;
      acc_en = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      do_reset();
      // R6 reset state
      chk("R6 irq after reset", 32'(pwr_irq), 32'd0);
      chk("R4 shutdown idle", 32'(shutdown_req), 32'd0);
      rd(3'd0, 2'd0, v); chk("R6 cfg cleared", v, 32'h0);
      rd(3'd3, 2'd0, v); chk("R6 aux1 cleared", v, 32'h0);
      rd(3'd4, 2'd0, v); chk("R6 aux2 cleared", v, 32'h0);
      rd(3'd2, 2'd0, v); chk("R6 modem cleared", v, 32'h0);

      for (int i = 0; i < NV; i++) begin
         if (VT[i].we) begin
            wr(VT[i].sel, VT[i].sz, VT[i].d);
            chk($sformatf("R8 no tc on vector %0d", i), 32'(fd_tc_pulse), 32'd0);
         end else begin
            rd(VT[i].sel, VT[i].sz, v);
            chk($sformatf("R%0d vector %0d", VT[i].req, i), v, VT[i].exp);
         end
      end

      // R10 no access
      @(negedge clk); acc_sel = 3'd1; acc_size = 2'd0; #1;
      chk("R10 rdata zero when idle", acc_rdata, 32'h0);

      // R8 terminal-count pulse
      wr(3'd3, 2'd0, 32'h81);
      chk("R8 tc pulse high", 32'(fd_tc_pulse), 32'd1);
      @(negedge clk); chk("R8 tc pulse one clock", 32'(fd_tc_pulse), 32'd0);
      rd(3'd3, 2'd0, v); chk("R8 aux1 stored byte", v, 32'h81);
      wr(3'd3, 2'd1, 32'h01);
      chk("R7 tc none on half write", 32'(fd_tc_pulse), 32'd0);

      // R4 / R3 power-down writes
      wr(3'd4, 2'd0, 32'hFF);
      chk("R4 shutdown pulse", 32'(shutdown_req), 32'd1);
      @(negedge clk); chk("R4 shutdown one clock", 32'(shutdown_req), 32'd0);
      rd(3'd4, 2'd0, v); chk("R3 masked write, no status set", v, 32'h03);

      // R2 input change with enable off
      wr(3'd0, 2'd0, 32'h00);
      @(negedge clk); pwr_fail_in = 1'b1;
      @(negedge clk); chk("R2 no status without enable irq", 32'(pwr_irq), 32'd0);
      rd(3'd4, 2'd0, v); chk("R2 no status without enable", v, 32'h03);
      pwr_fail_in = 1'b0;
      wr(3'd0, 2'd0, 32'h08);
      @(negedge clk); pwr_fail_in = 1'b1;
      @(negedge clk); chk("R1 irq raised", 32'(pwr_irq), 32'd1);
      rd(3'd4, 2'd0, v); chk("R2 status set", v, 32'h23);
      wr(3'd0, 2'd0, 32'h00);
      chk("R1 irq drops with enable", 32'(pwr_irq), 32'd0);
      wr(3'd0, 2'd0, 32'h08);
      chk("R1 irq back with enable", 32'(pwr_irq), 32'd1);
      wr(3'd4, 2'd0, 32'h02);
      chk("R3 clear drops irq", 32'(pwr_irq), 32'd0);
      chk("R4 no shutdown on clear", 32'(shutdown_req), 32'd0);
      rd(3'd4, 2'd0, v); chk("R3 status cleared", v, 32'h02);
      @(negedge clk); pwr_fail_in = 1'b0;
      @(negedge clk); pwr_fail_in = 1'b1;
      @(negedge clk); chk("R2 re-raise", 32'(pwr_irq), 32'd1);
      pwr_fail_in = 1'b0;
      @(negedge clk); chk("R2 deassert clears", 32'(pwr_irq), 32'd0);
      rd(3'd4, 2'd0, v); chk("R2 status bit clear", v, 32'h02);

      // R11 simultaneous clear and input rise
      @(negedge clk);
      acc_en = 1'b1; acc_we = 1'b1; acc_sel = 3'd4; acc_size = 2'd0; acc_wdata = 32'h02;
      pwr_fail_in = 1'b1;
      @(negedge clk);
      acc_en = 1'b0; acc_we = 1'b0;
      chk("R11 clear wins irq", 32'(pwr_irq), 32'd0);
      rd(3'd4, 2'd0, v); chk("R11 clear wins status", v, 32'h02);
      pwr_fail_in = 1'b0;
      @(negedge clk);

      // R5 system reset request
      wr(3'd6, 2'd2, 32'hFFFF0001);
      chk("R5 reset request pulse", 32'(sys_reset_req), 32'd1);
      @(negedge clk); chk("R5 reset request one clock", 32'(sys_reset_req), 32'd0);
      rd(3'd6, 2'd2, v); chk("R5 reset status value", v, 32'h2);

      // R9 halt
      wr(3'd7, 2'd0, 32'h5);
      chk("R9 halt pulse", 32'(cpu_halt_req), 32'd1);
      @(negedge clk); chk("R9 halt one clock", 32'(cpu_halt_req), 32'd0);
      rd(3'd7, 2'd0, v); chk("R9 idle reads zero", v, 32'h0);

      // R6 survivors across reset
      wr(3'd0, 2'd0, 32'h08);
      wr(3'd2, 2'd0, 32'h11);
      do_reset();
      rd(3'd1, 2'd0, v); chk("R6 diag kept", v, 32'hA5);
      rd(3'd5, 2'd1, v); chk("R6 led kept", v, 32'hBEEF);
      rd(3'd6, 2'd2, v); chk("R6 sys kept", v, 32'h2);
      rd(3'd0, 2'd0, v); chk("R6 cfg cleared again", v, 32'h0);
      rd(3'd2, 2'd0, v); chk("R6 modem cleared again", v, 32'h0);
      rd(3'd3, 2'd0, v); chk("R6 aux1 cleared again", v, 32'h0);

      finish_run();
   end
endmodule